// File: doc/BRIEF.md
# Flag-Setting Arithmetic and Logic Unit

This block is the datapath core that combines two 32-bit operands and keeps a four-bit condition code register. The first operand always comes from the primary register bus. The second operand comes either from the secondary bus, which carries a register or memory-buffer value, or from a 12-bit unsigned literal taken from the instruction word. When the literal is selected, its upper bits are filled with zeros. The unit computes add, subtract, bitwise AND, bitwise OR, move, compare and test. The result is combinational and appears in the same cycle as the operands.

The flags are Negative, Zero, Carry and oVerflow. They are latched on a rising clock edge only in two cases: when the instruction asserts its set-flags bit, or when the operation is compare or test. In every other case the register keeps its contents. Branch decision logic elsewhere reads the registered flags.

Compare and test do not deliver a result. For these two operations the destination-write strobe is held low.

Top module: `alu_ccr_unit`

## Requirements
- R1: With `op`=0 (ADD), `result` is `bus_p + operand_b` modulo 2^32. The carry candidate is the carry out of bit 31.
- R2: With `op`=1 (SUB), `result` is `bus_p - operand_b` modulo 2^32. The carry candidate is 1 when no borrow occurs, which means unsigned `bus_p >= operand_b`.
- R3: The bitwise opcodes behave as follows:
  - `op`=2 (AND) gives `bus_p & operand_b`.
  - `op`=3 (OR) gives `bus_p | operand_b`.
  - `op`=4 (MOV) gives `operand_b`.
- R4: Operand b is selected by `use_lit`:
  - When `use_lit`=1, operand b is `{20'b0, lit_field}`, a value from 0 to 4095, and `bus_q` is ignored.
  - When `use_lit`=0, operand b is `bus_q`.
- R5: `flags` is `{N,Z,C,V}` with N at bit 3 and V at bit 0. When N and Z are written:
  - Z becomes 1 exactly when all 32 result bits are zero.
  - N becomes result bit 31.
- R6: Overflow is computed per operation:
  - For ADD, V is set when both operands have the same sign and the sign of the result differs.
  - For SUB and CMP, the same test is applied with operand b inverted.
- R7: For ADD, SUB, AND, OR and MOV, the flags are written on the rising clock edge only when `set_flags`=1. When `set_flags`=0, all four flags hold their previous values.
- R8: CMP and TST write the flags on every rising clock edge, whatever the value of `set_flags`:
  - `op`=5 (CMP) computes the subtraction.
  - `op`=6 (TST) computes the AND.
- R9: `dest_we` is 1 for opcodes 0 to 4 and 0 for CMP, TST and the reserved opcode 7. Opcode 7 gives `result`=0 and never writes the flags.
- R10: AND, OR, MOV and TST write N and Z only. C and V keep their previous values.
- R11: The flags reset to 0000 asynchronously while `rst_n` is low. Updates resume after the synchronised release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code |
| set_flags | input | 1 | Flag write request for ADD/SUB/AND/OR/MOV |
| use_lit | input | 1 | Select the literal as operand b |
| bus_p | input | 32 | First operand |
| bus_q | input | 32 | Register or memory-buffer operand |
| lit_field | input | 12 | Unsigned literal from the instruction |
| result | output | 32 | Combinational result |
| dest_we | output | 1 | Destination register write strobe |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
`result` and `dest_we` are combinational, so they are due in the same cycle as the operands. The bench drives the operands on a falling edge and samples these two outputs one time unit later, before the next rising edge. `flags` is due one rising edge after the operation is presented, so the bench samples it on the following falling edge. The hold and reserved-opcode cases are checked by observing `flags` at that same point.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LIT_W  = 12;
  localparam int unsigned FLAG_W = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_MOV = 3'd4,
    OP_CMP = 3'd5,
    OP_TST = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } ccr_t;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIT_W  = 12
) (
  input  logic              use_lit,
  input  logic [DATA_W-1:0] bus_q,
  input  logic [LIT_W-1:0]  lit_field,
  output logic [DATA_W-1:0] operand_b
);
  localparam int unsigned PAD_W = DATA_W - LIT_W;

  logic [DATA_W-1:0] lit_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign lit_ext = {{PAD_W{1'b0}}, lit_field};
    end else begin : g_nopad
      assign lit_ext = lit_field[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    operand_b = use_lit ? lit_ext : bus_q;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              ovf,
  output logic              is_arith
);
  localparam int unsigned MSB = DATA_W - 1;

  logic              do_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;

  always_comb begin
    do_sub   = (op == OP_SUB) || (op == OP_CMP);
    is_arith = (op == OP_ADD) || do_sub;
    b_eff    = do_sub ? ~opb : opb;
    sum      = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
    carry    = sum[DATA_W];
    ovf      = (opa[MSB] & b_eff[MSB] & ~sum[MSB]) |
               (~opa[MSB] & ~b_eff[MSB] & sum[MSB]);
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: res = sum[DATA_W-1:0];
      OP_AND, OP_TST:         res = opa & opb;
      OP_OR:                  res = opa | opb;
      OP_MOV:                 res = opb;
      default:                res = '0;
    endcase
  end
endmodule

// File: rtl/alu_ccr_reg.sv
module alu_ccr_reg
  import alu_ccr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_nz,
  input  logic en_cv,
  input  ccr_t flag_in,
  output ccr_t flag_q
);
  ccr_t flag_d;

  always_comb begin
    flag_d = flag_q;
    if (en_nz) begin
      flag_d.n = flag_in.n;
      flag_d.z = flag_in.z;
    end
    if (en_cv) begin
      flag_d.c = flag_in.c;
      flag_d.v = flag_in.v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               flag_q <= '0;
    else if (en_nz || en_cv)  flag_q <= flag_d;
  end
endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
  import alu_ccr_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic          set_flags,
  input  logic          use_lit,
  input  logic [W-1:0]  bus_p,
  input  logic [W-1:0]  bus_q,
  input  logic [LW-1:0] lit_field,
  output logic [W-1:0]  result,
  output logic          dest_we,
  output logic [3:0]    flags
);
  alu_op_e  op_e;
  logic     rst_n_s;
  logic [W-1:0] operand_b;
  logic     carry, ovf, is_arith;
  logic     always_upd, upd_nz, upd_cv;
  ccr_t     flag_in, flag_q;

  assign op_e = alu_op_e'(op);

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  alu_operand_sel #(.DATA_W(W), .LIT_W(LW)) u_opsel (
    .use_lit(use_lit), .bus_q(bus_q), .lit_field(lit_field),
    .operand_b(operand_b)
  );

  alu_core #(.DATA_W(W)) u_core (
    .op(op_e), .opa(bus_p), .opb(operand_b), .res(result),
    .carry(carry), .ovf(ovf), .is_arith(is_arith)
  );

  always_comb begin
    always_upd = (op_e == OP_CMP) || (op_e == OP_TST);
    dest_we    = (op_e != OP_CMP) && (op_e != OP_TST) && (op_e != OP_RSV);
    upd_nz     = always_upd || (set_flags && dest_we);
    upd_cv     = upd_nz && is_arith;
    flag_in.n  = result[W-1];
    flag_in.z  = ~|result;
    flag_in.c  = carry;
    flag_in.v  = ovf;
  end

  alu_ccr_reg u_ccr (
    .clk(clk), .rst_n(rst_n_s), .en_nz(upd_nz), .en_cv(upd_cv),
    .flag_in(flag_in), .flag_q(flag_q)
  );

  assign flags = flag_q;

  // Flags hold when no write is requested (R7, R10 for C/V)
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!set_flags && op_e != OP_CMP && op_e != OP_TST) |=> $stable(flags));

  assert_cv_kept_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_e inside {OP_AND, OP_OR, OP_MOV, OP_TST}) |=> $stable(flags[1:0]));

  assert_cmp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_e == OP_CMP) |=> (flags[2] == ($past(bus_p) == $past(operand_b))));

  assert_neg_bit_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (set_flags && dest_we) |=> (flags[3] == $past(result[W-1])));

  assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_e inside {OP_CMP, OP_TST, OP_RSV}) |-> !dest_we);

  assert_lit_zext_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_e == OP_MOV && use_lit) |-> (result[W-1:LW] == '0));
endmodule

// File: tb/alu_ccr_unit_tb.sv
`timescale 1ns/1ps
module alu_ccr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic        set_flags, use_lit;
  logic [31:0] bus_p, bus_q;
  logic [11:0] lit_field;
  logic [31:0] result;
  logic        dest_we;
  logic [3:0]  flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alu_ccr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op(op), .set_flags(set_flags),
    .use_lit(use_lit), .bus_p(bus_p), .bus_q(bus_q), .lit_field(lit_field),
    .result(result), .dest_we(dest_we), .flags(flags)
  );

  task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, check comb outputs, then flags after next rise
  task automatic step(logic [2:0] o, logic sf, logic ul, logic [31:0] p,
                      logic [31:0] q, logic [11:0] l, string req,
                      bit chk_res, logic [31:0] exp_res, logic exp_we,
                      logic [3:0] exp_fl);
    @(negedge clk);
    op = o; set_flags = sf; use_lit = ul; bus_p = p; bus_q = q; lit_field = l;
    #1;
    if (chk_res) chk32({req, " result"}, result, exp_res);
    chk32({req, " dest_we"}, {31'b0, dest_we}, {31'b0, exp_we});
    @(negedge clk);
    chk32({req, " flags"}, {28'b0, flags}, {28'b0, exp_fl});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op = 3'd0; set_flags = 1'b0; use_lit = 1'b0;
    bus_p = '0; bus_q = '0; lit_field = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk32("R11 reset flags", {28'b0, flags}, 32'h0);
  endtask

  task automatic t_add();
    step(3'd0, 1, 0, 32'd1, 32'd2, 12'd0, "R1 add small", 1, 32'd3, 1, 4'b0000);
    step(3'd0, 1, 0, 32'hFFFF_FFFF, 32'd1, 12'd0, "R1 R5 add carry zero", 1, 32'd0, 1, 4'b0110);
    step(3'd0, 1, 0, 32'h7FFF_FFFF, 32'd1, 12'd0, "R6 add overflow", 1, 32'h8000_0000, 1, 4'b1001);
  endtask

  task automatic t_hold();
    step(3'd0, 0, 0, 32'd0, 32'd0, 12'd0, "R7 add no set", 1, 32'd0, 1, 4'b1001);
  endtask

  task automatic t_sub();
    step(3'd1, 1, 0, 32'd5, 32'd5, 12'd0, "R2 sub equal", 1, 32'd0, 1, 4'b0110);
    step(3'd1, 1, 0, 32'd3, 32'd5, 12'd0, "R2 sub borrow", 1, 32'hFFFF_FFFE, 1, 4'b1000);
    step(3'd1, 1, 0, 32'h8000_0000, 32'd1, 12'd0, "R6 sub overflow", 1, 32'h7FFF_FFFF, 1, 4'b0011);
  endtask

  task automatic t_logic();
    step(3'd2, 1, 0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 12'd0, "R3 R10 and", 1, 32'd0, 1, 4'b0111);
    step(3'd3, 1, 0, 32'h8000_0000, 32'd1, 12'd0, "R3 R10 or", 1, 32'h8000_0001, 1, 4'b1011);
    step(3'd4, 0, 0, 32'h1234_5678, 32'd0, 12'd0, "R3 R7 mov no set", 1, 32'd0, 1, 4'b1011);
  endtask

  task automatic t_lit();
    step(3'd0, 1, 1, 32'd1, 32'hFFFF_FFFF, 12'hFFF, "R4 add literal", 1, 32'h0000_1000, 1, 4'b0000);
    step(3'd4, 0, 1, 32'd0, 32'hDEAD_BEEF, 12'h800, "R4 mov literal", 1, 32'h0000_0800, 1, 4'b0000);
  endtask

  task automatic t_cmp_tst();
    step(3'd5, 0, 0, 32'd10, 32'd10, 12'd0, "R8 R9 cmp equal", 0, 32'd0, 0, 4'b0110);
    step(3'd6, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, 12'd0, "R8 R10 tst", 0, 32'd0, 0, 4'b1010);
    step(3'd5, 0, 1, 32'd100, 32'd0, 12'd200, "R8 R4 cmp literal", 0, 32'd0, 0, 4'b1000);
  endtask

  task automatic t_reserved();
    step(3'd7, 1, 0, 32'd7, 32'd9, 12'd0, "R9 reserved op", 1, 32'd0, 0, 4'b1000);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk32("R11 async reset", {28'b0, flags}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(3'd0, 1, 0, 32'hFFFF_FFFF, 32'd1, 12'd0, "R11 after reset", 1, 32'd0, 1, 4'b0110);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_add();
    t_hold();
    t_sub();
    t_logic();
    t_lit();
    t_cmp_tst();
    t_reserved();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule